// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block collects up to 32 interrupt sources into one sticky cause register and presents them to software through a small word-addressed register bus. Hardware raises a cause bit with a one-cycle pulse on its event input. Software can also raise a cause bit by writing to a set-only register. Each cause bit has its own control bit that picks how software acknowledges it. In the first mode, software writes a one to the bit. In the second mode, reading the bit clears it.

A mask register decides which causes reach the single level interrupt line. Software can write the mask whole, or change individual bits through a set alias and a clear alias, so no read-modify-write sequence is needed. A masked view of the cause register returns only the unmasked causes. That view acknowledges bits in the same way as the raw view. The interrupt line is the registered OR of the unmasked causes.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset the cause register and the mode register are all zeros, the mask is all ones and `irq_out` is 0.
- R2: Byte offsets are mode 0x00, cause 0x04, masked cause 0x08, software set 0x0C, mask 0x10, mask-set alias 0x14 and mask-clear alias 0x18. `rd_data` shows the addressed register in the same cycle as `rd_en`. The three set/clear-only registers and any other offset read as zero.
- R3: A one-cycle pulse on a bit of `hw_evt` sets the matching cause bit, whether or not that bit is masked. The bit then stays set until it is acknowledged.
- R4: Writing a one to a bit at offset 0x0C sets that cause bit. Zero bits have no effect.
- R5: A mode bit of 0 selects write-one-to-clear. A write to offset 0x04 or offset 0x08 clears the cause bits where `wr_data` is 1 and the mode bit is 0. Zero bits, and bits whose mode is 1, are unchanged.
- R6: A mode bit of 1 selects clear-on-read. A read of offset 0x04 clears the returned cause bits whose mode is 1. Reads never clear bits whose mode is 0.
- R7: A read of offset 0x08 returns cause AND NOT mask. It clears only those returned bits whose mode is 1, so masked bits survive the read.
- R8: When a hardware event or a software set lands in the same cycle as a write-clear or a read-clear of the same bit, the bit ends up set.
- R9: A write to offset 0x10 loads the mask. Ones written to 0x14 set mask bits and ones written to 0x18 clear mask bits. Zero bits of those two writes leave the mask unchanged. A mask bit of 1 blocks that source.
- R10: `irq_out` equals the OR of (cause AND NOT mask) as it stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_evt | input | NSRC | One-cycle hardware event pulses, one per source |
| addr | input | ADDR_W | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | NSRC | Write data |
| rd_en | input | 1 | Read strobe; side effects of the read apply at the clock edge |
| rd_data | output | NSRC | Read data, valid in the cycle of `rd_en` |
| irq_out | output | 1 | Level interrupt request |

## Verification
The bench targets the following corner cases:
- **Clear-on-read through the masked view.** The bench reads the masked view while some clear-on-read bits are masked. A design that clears every clear-on-read bit would lose those masked bits.
- **Event racing a clear.** The bench drives an event pulse in the same cycle as an acknowledge of the same bit. A design with the wrong priority would drop that event silently.
- **Writes aimed at clear-on-read bits.** A design that ignores the mode on writes would clear those bits.
- **Write-one-to-clear bits under reads.** The bench reads write-one-to-clear bits repeatedly. A design that ignores the mode on reads would clear them.
- **Interrupt latency.** The bench checks `irq_out` one cycle before and one cycle after a change, which exposes a missing or extra register stage.

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   hw_evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [NSRC-1:0]   wr_data,
  input  logic              rd_en,
  output logic [NSRC-1:0]   rd_data,
  output logic              irq_out
);
  localparam logic [ADDR_W-1:0] OFS_MODE  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_CAUSE = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_MCAUS = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_SWSET = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFS_MASK  = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFS_MSET  = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] OFS_MCLR  = ADDR_W'(8'h18);

  logic [NSRC-1:0] cause, mode, mask;
  logic [NSRC-1:0] visible, set_v, w1c_v, cor_v;
  logic            irq_q;

  assign visible = cause & ~mask;

  assign set_v = hw_evt | ((wr_en && addr == OFS_SWSET) ? wr_data : '0);
  assign w1c_v = (wr_en && (addr == OFS_CAUSE || addr == OFS_MCAUS)) ? (wr_data & ~mode) : '0;
  assign cor_v = !rd_en              ? '0 :
                 (addr == OFS_CAUSE) ? (cause & mode) :
                 (addr == OFS_MCAUS) ? (visible & mode) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause <= '0;
      mode  <= '0;
      mask  <= '1;
      irq_q <= 1'b0;
    end else begin
      cause <= (cause & ~(w1c_v | cor_v)) | set_v;
      irq_q <= |visible;
      if (wr_en) begin
        case (addr)
          OFS_MODE: mode <= wr_data;
          OFS_MASK: mask <= wr_data;
          OFS_MSET: mask <= mask | wr_data;
          OFS_MCLR: mask <= mask & ~wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (addr)
        OFS_MODE:  rd_data = mode;
        OFS_CAUSE: rd_data = cause;
        OFS_MCAUS: rd_data = visible;
        OFS_MASK:  rd_data = mask;
        default:   rd_data = '0;
      endcase
    end
  end

  assign irq_out = irq_q;

  // R3: an event pulse is held in cause on the next cycle
  a_r3_evt_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause & $past(hw_evt)) == $past(hw_evt)));

  // R6: a quiet read of the raw view empties its clear-on-read bits
  a_r6_cor_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == OFS_CAUSE && hw_evt == '0) |=> ((cause & $past(cause & mode)) == '0));

  // R5: writes never disturb clear-on-read bits
  a_r5_write_spares_cor: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && addr == OFS_CAUSE) |=> ((cause & $past(cause & mode)) == $past(cause & mode)));

  // R9: set alias raises every written one
  a_r9_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_MSET) |=> ((mask & $past(wr_data)) == $past(wr_data)));

  // R9: clear alias drops every written one
  a_r9_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_MCLR) |=> ((mask & $past(wr_data)) == '0));

  // R10: a fully masked bank keeps the line low
  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1) |=> !irq_out);
endmodule

// File: tb/tb_irq_cause_bank.sv
`timescale 1ns/1ps
module tb_irq_cause_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] hw_evt = '0;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  irq_cause_bank dut (
    .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq_out(irq_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [4:0] a, logic [31:0] evt, output logic [31:0] d);
    addr = a; rd_en = 1'b1; hw_evt = evt;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0; hw_evt = '0;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d, logic [31:0] evt);
    addr = a; wr_en = 1'b1; wr_data = d; hw_evt = evt;
    @(negedge clk);
    wr_en = 1'b0; hw_evt = '0;
  endtask

  task automatic rd_chk(string req, logic [4:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, '0, d);
    check(req, d, exp);
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 irq", {31'd0, irq_out}, 32'd0);
    rd_chk("R1 mode", 5'h00, 32'h0);
    rd_chk("R1 cause", 5'h04, 32'h0);
    rd_chk("R1 mask", 5'h10, 32'hFFFF_FFFF);
  endtask

  task automatic t_map();
    rd_chk("R2 swset reads 0", 5'h0C, 32'h0);
    rd_chk("R2 mset reads 0", 5'h14, 32'h0);
    rd_chk("R2 mclr reads 0", 5'h18, 32'h0);
    rd_chk("R2 unmapped reads 0", 5'h1C, 32'h0);
  endtask

  task automatic t_events();
    hw_evt = 32'h0000_00A5; @(negedge clk); hw_evt = '0;
    rd_chk("R3 masked events latched", 5'h04, 32'h0000_00A5);
    rd_chk("R6 read leaves w1c bits", 5'h04, 32'h0000_00A5);
    idle();
    check("R10 masked gives no irq", {31'd0, irq_out}, 32'd0);
  endtask

  task automatic t_mask();
    wr(5'h10, 32'h0, '0);
    rd_chk("R9 mask load", 5'h10, 32'h0);
    wr(5'h14, 32'h0F, '0);
    rd_chk("R9 mask set alias", 5'h10, 32'h0F);
    wr(5'h18, 32'h05, '0);
    rd_chk("R9 mask clear alias", 5'h10, 32'h0A);
    rd_chk("R7 masked view", 5'h08, 32'hA5);
    idle();
    check("R10 irq raised", {31'd0, irq_out}, 32'd1);
  endtask

  task automatic t_w1c();
    wr(5'h04, 32'h21, '0);
    rd_chk("R5 w1c via cause", 5'h04, 32'h84);
    wr(5'h08, 32'h04, '0);
    rd_chk("R5 w1c via masked view", 5'h04, 32'h80);
    wr(5'h04, 32'h0, '0);
    rd_chk("R5 zero write no effect", 5'h04, 32'h80);
  endtask

  task automatic t_swset();
    wr(5'h0C, 32'h300, '0);
    rd_chk("R4 software set", 5'h04, 32'h380);
  endtask

  task automatic t_cor();
    wr(5'h00, 32'h300, '0);
    rd_chk("R2 mode readback", 5'h00, 32'h300);
    wr(5'h04, 32'h100, '0);
    rd_chk("R5 write ignored on cor bit", 5'h04, 32'h380);
    rd_chk("R6 cor cleared by read", 5'h04, 32'h080);
  endtask

  task automatic t_masked_cor();
    wr(5'h0C, 32'h3000, '0);
    wr(5'h00, 32'h3300, '0);
    wr(5'h14, 32'h1000, '0);
    rd_chk("R7 masked read value", 5'h08, 32'h2080);
    rd_chk("R7 masked cor bit survives", 5'h04, 32'h1080);
    rd_chk("R6 raw read then clears", 5'h04, 32'h0080);
  endtask

  task automatic t_race();
    logic [31:0] d;
    wr(5'h04, 32'h80, 32'h80);
    rd_chk("R8 event beats w1c", 5'h04, 32'h80);
    wr(5'h0C, 32'h200, '0);
    rd(5'h04, 32'h200, d);
    check("R6 read returns", d, 32'h280);
    rd_chk("R8 event beats cor", 5'h04, 32'h280);
  endtask

  task automatic t_irq_timing();
    wr(5'h10, 32'hFFFF_FFFF, '0);
    idle();
    check("R10 irq drops when masked", {31'd0, irq_out}, 32'd0);
    wr(5'h00, 32'h0, '0);
    wr(5'h04, 32'hFFFF_FFFF, '0);
    wr(5'h10, 32'h0, '0);
    idle();
    check("R10 idle irq low", {31'd0, irq_out}, 32'd0);
    hw_evt = 32'h8000_0000; @(negedge clk); hw_evt = '0;
    check("R10 irq one cycle late", {31'd0, irq_out}, 32'd0);
    idle();
    check("R10 irq after lag", {31'd0, irq_out}, 32'd1);
  endtask

  initial begin
    #200_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_events();
    t_mask();
    t_w1c();
    t_swset();
    t_cor();
    t_masked_cor();
    t_race();
    t_irq_timing();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule